// File: doc/BRIEF.md
# Dual-Rail Minterm Function Block

This block computes two Boolean functions, e and f, from four dual-rail input variables a, b, c and d in a delay-insensitive minterm style. Each variable travels on a true rail and a false rail. Both rails low is the null (spacer) state. Exactly one rail high is a valid 1 or 0. Both rails high is illegal. The environment follows a four-phase return-to-null protocol: it presents a complete valid word, waits for the outputs to become valid, returns every input to null, then waits for the outputs to return to null.

The first stage is an array of sixteen Muller C-elements, one for each valid input word, so that a complete word raises exactly one minterm line. The second stage is a set of OR trees: the true rail of each output collects the minterms where that output is 1, and the false rail collects the rest. A parameter selects how the minterm array is built. The flat variant uses sixteen four-input C-elements. The shared variant first forms four a/b pair terms and four c/d pair terms, then combines one of each, for 24 two-input C-elements. Each C-element keeps its hysteresis state in a register that the clock refreshes. An active-low asynchronous reset clears that state so operation begins in null.

Top module: `dims_func_top`

## Requirements
- R1: While and just after rst_ni is low with all inputs null, every output rail is 0.
- R2: A variable is encoded as true rail high for 1, false rail high for 0, both low for null. Variables map to rail index 3=a, 2=b, 1=c, 0=d. With a complete valid word, output e (rail index 1) equals d OR (a XNOR b): for value 1 the true rail is high and the false rail low, and the reverse for value 0.
- R3: With a complete valid word, output f (rail index 0) equals (NOT a AND NOT b AND NOT c) OR (NOT a AND b AND c AND NOT d) OR (a AND d), using the same rail encoding.
- R4: While at least one input variable is still null and the outputs were null, both outputs stay null.
- R5: Once the outputs are valid, they hold their value while any input rail is still high. They return to null once every input is null.
- R6: No output ever has both rails high, and with a complete valid word each output has exactly one rail high.
- R7: The flat variant (SHARED_TERMS=0) and the shared variant (SHARED_TERMS=1) produce the same outputs for every input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that refreshes the C-element hold state |
| rst_ni | input | 1 | Active-low asynchronous reset of all C-element states |
| in_t_i | input | 4 | True rails of variables a, b, c, d (index 3 down to 0) |
| in_f_i | input | 4 | False rails of variables a, b, c, d (index 3 down to 0) |
| out_t_o | output | 2 | True rails of outputs e (index 1) and f (index 0) |
| out_f_o | output | 2 | False rails of outputs e (index 1) and f (index 0) |

## Verification
The bench sweeps all sixteen valid words through both variants. Before each word it presents a partial word with a different variable still missing. A decoder without hysteresis would produce a premature output here. After each word it returns one variable to null first. A C-element that resets on any falling input would drop its output early at this point. The final full null then shows whether a stuck minterm leaves an output valid. A wrong OR-tree connection shows up as a miscompare against the arithmetic forms of e and f, and as an output with both rails high or neither rail high.

// File: rtl/dims_func_pkg.sv
package dims_func_pkg;
  localparam int unsigned NUM_VARS     = 4;
  localparam int unsigned NUM_MINTERMS = 1 << NUM_VARS;
  localparam int unsigned NUM_OUTS     = 2;
  localparam int unsigned HALF_VARS    = NUM_VARS / 2;
  localparam int unsigned NUM_PAIRS    = 1 << HALF_VARS;

  typedef logic [NUM_MINTERMS-1:0] minterm_t;

  // bit m set: output is 1 for word m = {a,b,c,d}; index 1 = e, index 0 = f
  localparam minterm_t OUT_TABLE [NUM_OUTS] = '{16'hAA43, 16'hFAAF};
endpackage

// File: rtl/dims_celem.sv
module dims_celem #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic         out_o
);
  logic state_q;
  logic all_hi, all_lo;

  assign all_hi = &in_i;
  assign all_lo = ~|in_i;
  // set on all-high, clear on all-low, else hold
  assign out_o  = all_hi | (state_q & ~all_lo);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= 1'b0;
    else         state_q <= out_o;
  end
endmodule

// File: rtl/dims_minterm_flat.sv
module dims_minterm_flat
  import dims_func_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_VARS-1:0] in_t_i,
  input  logic [NUM_VARS-1:0] in_f_i,
  output minterm_t            minterm_o
);
  for (genvar m = 0; m < NUM_MINTERMS; m++) begin : g_term
    logic [NUM_VARS-1:0] sel;
    for (genvar k = 0; k < NUM_VARS; k++) begin : g_rail
      if (((m >> k) & 1) == 1) begin : g_t
        assign sel[k] = in_t_i[k];
      end else begin : g_f
        assign sel[k] = in_f_i[k];
      end
    end
    dims_celem #(.N(NUM_VARS)) u_c (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  (sel),
      .out_o (minterm_o[m])
    );
  end
endmodule

// File: rtl/dims_minterm_shared.sv
module dims_minterm_shared
  import dims_func_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_VARS-1:0] in_t_i,
  input  logic [NUM_VARS-1:0] in_f_i,
  output minterm_t            minterm_o
);
  logic [NUM_PAIRS-1:0] hi_pair, lo_pair;

  // hi_pair[p]: a/b (index 3,2); lo_pair[p]: c/d (index 1,0)
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic [1:0] hi_sel, lo_sel;
    for (genvar j = 0; j < 2; j++) begin : g_bit
      if (((p >> j) & 1) == 1) begin : g_t
        assign hi_sel[j] = in_t_i[j+2];
        assign lo_sel[j] = in_t_i[j];
      end else begin : g_f
        assign hi_sel[j] = in_f_i[j+2];
        assign lo_sel[j] = in_f_i[j];
      end
    end
    dims_celem #(.N(2)) u_hi (
      .clk_i(clk_i), .rst_ni(rst_ni), .in_i(hi_sel), .out_o(hi_pair[p])
    );
    dims_celem #(.N(2)) u_lo (
      .clk_i(clk_i), .rst_ni(rst_ni), .in_i(lo_sel), .out_o(lo_pair[p])
    );
  end

  for (genvar m = 0; m < NUM_MINTERMS; m++) begin : g_term
    dims_celem #(.N(2)) u_c (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .in_i  ({hi_pair[m / NUM_PAIRS], lo_pair[m % NUM_PAIRS]}),
      .out_o (minterm_o[m])
    );
  end
endmodule

// File: rtl/dims_or_stage.sv
module dims_or_stage
  import dims_func_pkg::*;
(
  input  minterm_t            minterm_i,
  output logic [NUM_OUTS-1:0] out_t_o,
  output logic [NUM_OUTS-1:0] out_f_o
);
  for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
    assign out_t_o[o] = |(minterm_i &  OUT_TABLE[o]);
    assign out_f_o[o] = |(minterm_i & ~OUT_TABLE[o]);
  end
endmodule

// File: rtl/dims_func_top.sv
module dims_func_top
  import dims_func_pkg::*;
#(
  parameter bit SHARED_TERMS = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_VARS-1:0] in_t_i,
  input  logic [NUM_VARS-1:0] in_f_i,
  output logic [NUM_OUTS-1:0] out_t_o,
  output logic [NUM_OUTS-1:0] out_f_o
);
  minterm_t minterm;

  if (SHARED_TERMS) begin : g_shared
    dims_minterm_shared u_terms (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .in_t_i(in_t_i), .in_f_i(in_f_i), .minterm_o(minterm)
    );
  end else begin : g_flat
    dims_minterm_flat u_terms (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .in_t_i(in_t_i), .in_f_i(in_f_i), .minterm_o(minterm)
    );
  end

  dims_or_stage u_or (
    .minterm_i(minterm),
    .out_t_o  (out_t_o),
    .out_f_o  (out_f_o)
  );
endmodule

// File: rtl/dims_func_chk.sv
module dims_func_chk
  import dims_func_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_VARS-1:0] in_t_i,
  input logic [NUM_VARS-1:0] in_f_i,
  input logic [NUM_OUTS-1:0] out_t_o,
  input logic [NUM_OUTS-1:0] out_f_o,
  input minterm_t            minterm_i
);
  logic out_null, in_all_null, in_some_null, in_complete, out_valid, in_any_hi;

  assign out_null     = ~|(out_t_o | out_f_o);
  assign out_valid    = &(out_t_o ^ out_f_o);
  assign in_all_null  = ~|(in_t_i | in_f_i);
  assign in_some_null = |(~(in_t_i | in_f_i));
  assign in_any_hi    = |(in_t_i | in_f_i);
  assign in_complete  = &(in_t_i ^ in_f_i);

  assert_reset_null_R1: assert property (@(posedge clk_i)
    !rst_ni |-> out_null);

  assert_onehot_minterm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(minterm_i));

  assert_partial_null_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(out_null) && in_some_null |-> out_null);

  assert_hold_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(out_valid) && in_any_hi |-> $stable(out_t_o) && $stable(out_f_o));

  assert_return_null_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_all_null |-> out_null);

  assert_no_both_rails_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ~|(out_t_o & out_f_o));

  assert_complete_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_complete |-> out_valid);
endmodule

bind dims_func_top dims_func_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .in_t_i   (in_t_i),
  .in_f_i   (in_f_i),
  .out_t_o  (out_t_o),
  .out_f_o  (out_f_o),
  .minterm_i(minterm)
);

// File: tb/dims_func_top_tb_top.sv
`timescale 1ns/1ps
module dims_func_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] in_t = '0, in_f = '0;
  logic [1:0] fl_t, fl_f, sh_t, sh_f;
  int unsigned n_vec = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dims_func_top #(.SHARED_TERMS(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_t_i(in_t), .in_f_i(in_f),
    .out_t_o(fl_t), .out_f_o(fl_f)
  );
  dims_func_top #(.SHARED_TERMS(1'b1)) dut_sh_i (
    .clk_i(clk), .rst_ni(rst_n), .in_t_i(in_t), .in_f_i(in_f),
    .out_t_o(sh_t), .out_f_o(sh_f)
  );

  function automatic logic exp_e(input int m);
    logic a = m[3], b = m[2], d = m[0];
    return d | ~(a ^ b);
  endfunction
  function automatic logic exp_f(input int m);
    logic a = m[3], b = m[2], c = m[1], d = m[0];
    return (~a & ~b & ~c) | (~a & b & c & ~d) | (a & d);
  endfunction

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got rails t/f=%b expected %b", req, got, exp);
    end
  endtask

  // drive word m with variables in 'mask' valid, others null
  task automatic drive(input int m, input logic [3:0] mask);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      in_t[k] = mask[k] &  m[k];
      in_f[k] = mask[k] & ~m[k];
    end
    @(posedge clk);
    #1;
  endtask

  task automatic chk_both(input string req, input logic [1:0] exp_e_r, input logic [1:0] exp_f_r);
    chk({req, " e flat"},   {fl_t[1], fl_f[1]}, exp_e_r);
    chk({req, " f flat"},   {fl_t[0], fl_f[0]}, exp_f_r);
    chk({req, " e shared R7"}, {sh_t[1], sh_f[1]}, exp_e_r);
    chk({req, " f shared R7"}, {sh_t[0], sh_f[0]}, exp_f_r);
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk_both("R1 reset", 2'b00, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk_both("R1 after reset", 2'b00, 2'b00);
    for (int m = 0; m < 16; m++) begin
      logic [1:0] ee, ff;
      int miss, drop;
      ee = exp_e(m) ? 2'b10 : 2'b01;
      ff = exp_f(m) ? 2'b10 : 2'b01;
      miss = m % 4;
      drop = (m + 1) % 4;
      drive(m, ~(4'b0001 << miss));
      chk_both("R4 partial word", 2'b00, 2'b00);
      drive(m, 4'b1111);
      chk({"R2 e flat"},   {fl_t[1], fl_f[1]}, ee);
      chk({"R3 f flat"},   {fl_t[0], fl_f[0]}, ff);
      chk({"R7 e shared"}, {sh_t[1], sh_f[1]}, ee);
      chk({"R7 f shared"}, {sh_t[0], sh_f[0]}, ff);
      chk("R6 exclusive rails", {|(fl_t & fl_f), |(sh_t & sh_f)}, 2'b00);
      drive(m, ~(4'b0001 << drop));
      chk_both("R5 hold", ee, ff);
      drive(m, 4'b0000);
      chk_both("R5 return null", 2'b00, 2'b00);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule